// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers the interrupt causes of an Ethernet MAC into one status register and drives a single interrupt line. The causes are:

- power-management wake-up events,
- receive and transmit statistics-counter interrupts,
- a match of the system time against a programmed target time.

Each status bit follows its own clearing rule:

- The timestamp bit is cleared by reading the status register.
- The wake-up bit is cleared only by reading the power-management control register.
- The counter bits are a live OR of two small write-one-to-clear source registers.

Software reaches the block through a simple register bus with single-cycle write and read strobes. Read data is registered and appears one cycle after the read strobe. The block holds the system-time comparator, a minimal power-management control register and the two counter interrupt source registers. Wake-up detection and the counters themselves lie outside; they deliver single-cycle pulses.

Top module: `eth_irq_hub`

## Requirements
- R1: After synchronous reset every register reads zero, `irq` is low and `reg_rdata` is zero.
- R2: The status register at offset 0x38 carries the wake-up summary in bit 3, the counter summary in bit 4, the receive counter summary in bit 5, the transmit counter summary in bit 6 and the timestamp bit in bit 9. All other bits read zero, and writes to this offset change nothing.
- R3: The power-management register at offset 0x2C has a writable power-down enable in bit 0. While that bit is 1, a `wake_magic` pulse sets the read-only flag in bit 5 and a `wake_frame` pulse sets the read-only flag in bit 6. While it is 0, both pulses are ignored. Status bit 3 is the OR of the two flags.
- R4: Reading offset 0x2C returns the flags and clears them in the same cycle, so status bit 3 falls. Reading the status register leaves the flags untouched. If a flag is set in the same cycle as the clearing read, the set wins.
- R5: The receive source register at offset 0x48 is MMC_N bits wide. It captures `mmc_rx_set` pulses, and writing 1 to a bit clears that bit. A set and a clear of the same bit in the same cycle leave the bit at 1. Status bit 5 is high exactly while any bit of this register is 1.
- R6: The transmit source register at offset 0x4C behaves like the receive register, driven by `mmc_tx_set`, and feeds status bit 6.
- R7: Status bit 4 is high whenever bit 5 or bit 6 is high, and low only when both are low.
- R8: Writing the target register at offset 0x44 loads TIME_W bits and arms the comparator. Status bit 9 sets once, in the cycle after `sys_time` is first equal to or above the target. It does not set again until the target is rewritten. After reset the comparator is disarmed.
- R9: Reading the status register clears bit 9. When a match and that read fall in the same cycle, bit 9 stays 1.
- R10: The mask register at offset 0x3C holds one writable bit at bit 3; all other bits read zero. When that bit is 1, wake-up status no longer drives `irq`, but status bit 3 still records the event.
- R11: `irq` is a register. It is high in the cycle after any status bit that is not masked is high.
- R12: `reg_rdata` holds the addressed register's value in the cycle after a read strobe. It holds zero after a cycle without a read or after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| wake_magic | input | 1 | Magic wake-up packet seen (pulse) |
| wake_frame | input | 1 | Wake-up frame seen (pulse) |
| mmc_rx_set | input | MMC_N | Receive counter interrupt set pulses |
| mmc_tx_set | input | MMC_N | Transmit counter interrupt set pulses |
| sys_time | input | TIME_W | Current system time |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with TIME_W of 16 and MMC_N of 3. The narrow time lets the test step `sys_time` across the target by single counts, so it hits the equal and just-below cases exactly. The three-bit source registers leave room to clear one bit while another stays set, and to set and clear the same bit in one cycle. A behavioural model predicts `reg_rdata` and `irq` on every clock. This covers every same-cycle collision of a set with a clearing read or write.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam logic [7:0] OFS_PMT  = 8'h2C;
  localparam logic [7:0] OFS_STAT = 8'h38;
  localparam logic [7:0] OFS_MASK = 8'h3C;
  localparam logic [7:0] OFS_TGT  = 8'h44;
  localparam logic [7:0] OFS_MRX  = 8'h48;
  localparam logic [7:0] OFS_MTX  = 8'h4C;

  localparam int B_PMT = 3;
  localparam int B_MMC = 4;
  localparam int B_MRX = 5;
  localparam int B_MTX = 6;
  localparam int B_TS  = 9;

  localparam int P_PD   = 0;
  localparam int P_MAG  = 5;
  localparam int P_WAKE = 6;
endpackage

// File: rtl/eth_irq_pmt.sv
module eth_irq_pmt
  import eth_irq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic          magic_i,
  input  logic          frame_i,
  output logic          pmt_st,
  output logic [DW-1:0] csr_val
);
  logic pd_q, mag_q, wk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q  <= 1'b0;
      mag_q <= 1'b0;
      wk_q  <= 1'b0;
    end else begin
      if (wr) pd_q <= wdata[P_PD];
      // a flag raised in the cycle of the clearing read survives it
      mag_q <= (pd_q & magic_i) | (mag_q & ~rd);
      wk_q  <= (pd_q & frame_i) | (wk_q & ~rd);
    end
  end

  assign pmt_st = mag_q | wk_q;

  always_comb begin
    csr_val         = '0;
    csr_val[P_PD]   = pd_q;
    csr_val[P_MAG]  = mag_q;
    csr_val[P_WAKE] = wk_q;
  end

  assert_pd_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!pd_q && !pmt_st) |=> !pmt_st);
  assert_rd_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rd && !(pd_q && (magic_i || frame_i))) |=> !pmt_st);
endmodule

// File: rtl/eth_irq_w1c.sv
module eth_irq_w1c #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] val_q,
  output logic         any_o
);
  logic [N-1:0] clr;
  assign clr = wr ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) val_q <= '0;
    else     val_q <= (val_q & ~clr) | set_i;
  end

  assign any_o = |val_q;

  // R5 / R6: a set pulse always lands, even against a clearing write
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((val_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/eth_irq_tstamp.sv
module eth_irq_tstamp #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_tgt,
  input  logic [TW-1:0] wdata_t,
  input  logic [TW-1:0] sys_time,
  input  logic          clr,
  output logic          ts_q,
  output logic [TW-1:0] tgt_q
);
  logic armed_q;
  logic hit;

  assign hit = armed_q && (sys_time >= tgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q   <= '0;
      armed_q <= 1'b0;
      ts_q    <= 1'b0;
    end else begin
      if (wr_tgt) begin
        tgt_q   <= wdata_t;
        armed_q <= 1'b1;
      end else if (hit) begin
        armed_q <= 1'b0;
      end
      ts_q <= hit | (ts_q & ~clr);
    end
  end

  assert_ts_set_R8: assert property (@(posedge clk) disable iff (rst)
    (armed_q && (sys_time >= tgt_q)) |=> ts_q);
  assert_ts_once_R8: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !wr_tgt && !ts_q) |=> !ts_q);
  assert_ts_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr && ts_q && !(armed_q && (sys_time >= tgt_q))) |=> !ts_q);
endmodule

// File: rtl/eth_irq_hub.sv
module eth_irq_hub
  import eth_irq_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int TIME_W = 32,
  parameter int MMC_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              wake_magic,
  input  logic              wake_frame,
  input  logic [MMC_N-1:0]  mmc_rx_set,
  input  logic [MMC_N-1:0]  mmc_tx_set,
  input  logic [TIME_W-1:0] sys_time,
  output logic              irq
);
  localparam int NSRC = 2;
  localparam logic [DW-1:0] STAT_USED =
    DW'((1 << B_PMT) | (1 << B_MMC) | (1 << B_MRX) | (1 << B_MTX) | (1 << B_TS));

  logic sel_pmt, sel_stat, sel_mask, sel_tgt;
  assign sel_pmt  = (reg_addr == AW'(OFS_PMT));
  assign sel_stat = (reg_addr == AW'(OFS_STAT));
  assign sel_mask = (reg_addr == AW'(OFS_MASK));
  assign sel_tgt  = (reg_addr == AW'(OFS_TGT));

  logic              pmt_st;
  logic [DW-1:0]     pmt_val;
  logic              ts_st;
  logic [TIME_W-1:0] tgt_val;
  logic              mask_q;
  logic              irq_q;
  logic [DW-1:0]     rdata_q;
  logic [DW-1:0]     status;
  logic [DW-1:0]     rd_mux;

  logic [MMC_N-1:0] src_set [NSRC];
  logic [MMC_N-1:0] src_val [NSRC];
  logic [NSRC-1:0]  src_any;
  logic [NSRC-1:0]  src_sel;

  assign src_set[0] = mmc_rx_set;
  assign src_set[1] = mmc_tx_set;
  assign src_sel[0] = (reg_addr == AW'(OFS_MRX));
  assign src_sel[1] = (reg_addr == AW'(OFS_MTX));

  eth_irq_pmt #(.DW(DW)) u_pmt (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr && sel_pmt),
    .rd      (reg_rd && sel_pmt),
    .wdata   (reg_wdata),
    .magic_i (wake_magic),
    .frame_i (wake_frame),
    .pmt_st  (pmt_st),
    .csr_val (pmt_val)
  );

  genvar k;
  generate
    for (k = 0; k < NSRC; k++) begin : g_src
      eth_irq_w1c #(.N(MMC_N)) u_src (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr && src_sel[k]),
        .wbits (reg_wdata[MMC_N-1:0]),
        .set_i (src_set[k]),
        .val_q (src_val[k]),
        .any_o (src_any[k])
      );
    end
  endgenerate

  eth_irq_tstamp #(.TW(TIME_W)) u_ts (
    .clk      (clk),
    .rst      (rst),
    .wr_tgt   (reg_wr && sel_tgt),
    .wdata_t  (reg_wdata[TIME_W-1:0]),
    .sys_time (sys_time),
    .clr      (reg_rd && sel_stat),
    .ts_q     (ts_st),
    .tgt_q    (tgt_val)
  );

  always_comb begin
    status        = '0;
    status[B_PMT] = pmt_st;
    status[B_MRX] = src_any[0];
    status[B_MTX] = src_any[1];
    status[B_MMC] = |src_any;
    status[B_TS]  = ts_st;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_pmt)    rd_mux = pmt_val;
    if (sel_stat)   rd_mux = status;
    if (sel_mask)   rd_mux[B_PMT] = mask_q;
    if (sel_tgt)    rd_mux = DW'(tgt_val);
    if (src_sel[0]) rd_mux = DW'(src_val[0]);
    if (src_sel[1]) rd_mux = DW'(src_val[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (reg_wr && sel_mask) mask_q <= reg_wdata[B_PMT];
      irq_q   <= |(status & ~(DW'(mask_q) << B_PMT));
      rdata_q <= reg_rd ? rd_mux : '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel_stat) |=> ((reg_rdata & ~STAT_USED) == '0));
  assert_mmc_sum_R7: assert property (@(posedge clk) disable iff (rst)
    status[B_MMC] == (status[B_MRX] || status[B_MTX]));
  assert_mask_pmt_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_q && ((status & ~(DW'(1) << B_PMT)) == '0)) |=> !irq);
  assert_irq_ts_R11: assert property (@(posedge clk) disable iff (rst)
    status[B_TS] |=> irq);
  assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

// File: tb/eth_irq_hub_bench.sv
module eth_irq_hub_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int TW = 16;
  localparam int MN = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          wake_magic = 1'b0;
  logic          wake_frame = 1'b0;
  logic [MN-1:0] mmc_rx_set = '0;
  logic [MN-1:0] mmc_tx_set = '0;
  logic [TW-1:0] sys_time = '0;
  logic          irq;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  eth_irq_hub #(.AW(AW), .DW(DW), .TIME_W(TW), .MMC_N(MN)) u_eth_irq_hub (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_magic(wake_magic),
    .wake_frame(wake_frame), .mmc_rx_set(mmc_rx_set), .mmc_tx_set(mmc_tx_set),
    .sys_time(sys_time), .irq(irq)
  );

  // behavioural reference model
  bit            m_pd, m_mag, m_wk, m_mask, m_armed, m_ts, m_irq;
  logic [MN-1:0] m_rx, m_tx;
  logic [TW-1:0] m_tgt;
  logic [DW-1:0] m_rdata;

  always @(posedge clk) begin
    logic [DW-1:0] st, rv;
    bit hit;
    if (rst) begin
      m_pd = 0; m_mag = 0; m_wk = 0; m_mask = 0; m_armed = 0; m_ts = 0; m_irq = 0;
      m_rx = '0; m_tx = '0; m_tgt = '0; m_rdata = '0;
    end else begin
      st = '0;
      st[3] = m_mag | m_wk;
      st[5] = (m_rx != 0);
      st[6] = (m_tx != 0);
      st[4] = st[5] | st[6];
      st[9] = m_ts;
      rv = '0;
      case (reg_addr)
        8'h2C: begin rv[0] = m_pd; rv[5] = m_mag; rv[6] = m_wk; end
        8'h38: rv = st;
        8'h3C: rv[3] = m_mask;
        8'h44: rv = DW'(m_tgt);
        8'h48: rv = DW'(m_rx);
        8'h4C: rv = DW'(m_tx);
        default: rv = '0;
      endcase
      hit = m_armed && (sys_time >= m_tgt);
      m_irq = (st[9] | st[6] | st[5] | st[4]) | (st[3] & !m_mask);
      m_rdata = reg_rd ? rv : '0;
      m_mag = (m_pd & wake_magic) | (m_mag & !(reg_rd && reg_addr == 8'h2C));
      m_wk  = (m_pd & wake_frame) | (m_wk  & !(reg_rd && reg_addr == 8'h2C));
      m_ts  = hit | (m_ts & !(reg_rd && reg_addr == 8'h38));
      if (reg_wr && reg_addr == 8'h48) m_rx = m_rx & ~reg_wdata[MN-1:0];
      if (reg_wr && reg_addr == 8'h4C) m_tx = m_tx & ~reg_wdata[MN-1:0];
      m_rx = m_rx | mmc_rx_set;
      m_tx = m_tx | mmc_tx_set;
      if (reg_wr && reg_addr == 8'h2C) m_pd = reg_wdata[0];
      if (reg_wr && reg_addr == 8'h3C) m_mask = reg_wdata[3];
      if (reg_wr && reg_addr == 8'h44) begin m_tgt = reg_wdata[TW-1:0]; m_armed = 1; end
      else if (hit) m_armed = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_vec++;
      if (reg_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s reg_rdata actual %h expected %h", cur_req, reg_rdata, m_rdata);
      end
      n_vec++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq actual %b expected %b", cur_req, irq, m_irq);
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
    reg_wr = 0; reg_rd = 0; wake_magic = 0; wake_frame = 0;
    mmc_rx_set = '0; mmc_tx_set = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_rd = 0; reg_addr = a; reg_wdata = d;
    step();
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); #1;
    reg_rd = 1; reg_wr = 0; reg_addr = a;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    idle(3);
    @(negedge clk); #1; rst = 0;
    // R1: reset values of every register
    cur_req = "R1";
    rd(8'h38); rd(8'h3C); rd(8'h2C); rd(8'h44); rd(8'h48); rd(8'h4C); idle(1);
    // R2: writes to status ignored, reserved bits zero
    cur_req = "R2";
    wr(8'h38, 32'hFFFF_FFFF); rd(8'h38); idle(1);
    // R12: unmapped read returns zero
    cur_req = "R12";
    rd(8'h10); rd(8'h3A); idle(1);
    // R3: wake pulses ignored outside power-down
    cur_req = "R3";
    @(negedge clk); #1; wake_magic = 1; step();
    rd(8'h38); rd(8'h2C);
    wr(8'h2C, 32'h1);
    @(negedge clk); #1; wake_magic = 1; step();
    rd(8'h38); rd(8'h2C); rd(8'h38);
    // R4: status read does not clear; set beats clearing read
    cur_req = "R4";
    @(negedge clk); #1; wake_frame = 1; step();
    rd(8'h38); rd(8'h38); idle(2);
    @(negedge clk); #1; reg_rd = 1; reg_addr = 8'h2C; wake_frame = 1; step();
    rd(8'h38); rd(8'h2C); rd(8'h38); idle(1);
    // R10: mask hides wake-up from irq
    cur_req = "R10";
    wr(8'h3C, 32'hFFFF_FFFF); rd(8'h3C);
    @(negedge clk); #1; wake_magic = 1; step();
    idle(2); rd(8'h38); rd(8'h2C); idle(1);
    @(negedge clk); #1; wake_frame = 1; step();
    wr(8'h3C, 32'h0); idle(2); rd(8'h2C); idle(2);
    // R5: receive source register
    cur_req = "R5";
    @(negedge clk); #1; mmc_rx_set = 3'b101; step();
    rd(8'h48); rd(8'h38); wr(8'h48, 32'h1); rd(8'h48); rd(8'h38);
    @(negedge clk); #1; reg_wr = 1; reg_addr = 8'h48; reg_wdata = 32'h4; mmc_rx_set = 3'b100; step();
    rd(8'h48); wr(8'h48, 32'h7); rd(8'h48); rd(8'h38);
    // R6: transmit source register
    cur_req = "R6";
    @(negedge clk); #1; mmc_tx_set = 3'b010; step();
    rd(8'h4C); rd(8'h38); wr(8'h4C, 32'h2); rd(8'h38); idle(1);
    // R7: summary follows both sources
    cur_req = "R7";
    @(negedge clk); #1; mmc_rx_set = 3'b001; mmc_tx_set = 3'b100; step();
    rd(8'h38); wr(8'h48, 32'h1); rd(8'h38); wr(8'h4C, 32'h4); rd(8'h38); idle(1);
    // R8: target compare, set once, re-arm on rewrite
    cur_req = "R8";
    sys_time = 16'd100;
    wr(8'h44, 32'd200); rd(8'h44);
    sys_time = 16'd199; idle(2);
    sys_time = 16'd200; idle(1);
    sys_time = 16'd201; idle(1);
    rd(8'h38); sys_time = 16'd500; idle(3); rd(8'h38);
    wr(8'h44, 32'd150); idle(2); rd(8'h38); idle(1);
    // R9: clearing read loses against a same-cycle match
    cur_req = "R9";
    sys_time = 16'd250;
    wr(8'h44, 32'd300); idle(1);
    @(negedge clk); #1; sys_time = 16'd300; reg_rd = 1; reg_addr = 8'h38; step();
    rd(8'h38); rd(8'h38); idle(1);
    // R11: irq from combined sources
    cur_req = "R11";
    @(negedge clk); #1; mmc_tx_set = 3'b001; step();
    idle(2); wr(8'h4C, 32'h1); idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule